// File: doc/BRIEF.md
# Power-Fail Bus Isolation Controller

This block decides when the host-side register interface must be cut off from the internal register file after the system's power-fail input goes low. It watches an active-low, asynchronous power-fail input and a 1 kHz tick strobe. It drives a lockout flag, gated copies of the host select, read, write and address signals, an output-enable for the data bus, and a sticky power-fail status bit.

Lockout can be reached in three ways. The default path waits a fixed number of ticks. An optional grace window keeps the bus usable much longer, and software can end it early by clearing the grace enable. A safety override forces lockout when a host access stays asserted for too long after power fail. An access that is already under way when lockout falls due is allowed to finish first. Once locked out, the block stays locked out for as long as the power-fail input remains low. It releases on a tick that finds power restored and no access pending.

Top module: `pfl_bus_guard`

## Requirements
- R1: While not locked out, the host strobes (active-low `host_cs_n`, `host_rd_n`, `host_wr_n`) appear as active-high `core_sel`, `core_rd`, `core_wr` one clock later, and `host_addr` appears on `core_addr` one clock later. `dbus_oe` goes high one clock after select and read are both low.
- R2: `pwr_fail_n` passes through a two-flop synchronizer. With `grace_en` low when power fail is detected, `lockout` stays low through the 31st tick after detection and is high after the 32nd tick.
- R3: With `grace_en` high when power fail is detected, `lockout` stays low through the 479th tick and is high after the 480th tick.
- R4: Clearing `grace_en` during the grace window asserts `lockout` within three clocks, without waiting for a tick.
- R5: If lockout falls due while select together with read or write is active, lockout waits until that access ends. The access keeps being passed to the core until then.
- R6: An access held continuously from detection through 31 ticks forces lockout after the 31st tick, even inside a grace window. After only 30 ticks it does not.
- R7: While `lockout` is high, `core_sel`, `core_rd`, `core_wr`, `dbus_oe` and `core_addr` are all zero, whatever the host drives.
- R8: Lockout holds while power fail stays low. It releases on the first tick that sees power restored with no access active. A held access delays the release to a later tick.
- R9: `pf_status` is zero after reset and sets when power fail is detected. A one-clock `sts_clr` pulse clears it only while power is restored. While power fail is still low, the pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-clock strobe at 1 kHz |
| pwr_fail_n | input | 1 | Asynchronous power-fail input, low means failing |
| grace_en | input | 1 | Grace-window enable bit from the register file |
| sts_clr | input | 1 | Write-one pulse clearing the status bit |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | ADDR_W | Host register address |
| lockout | output | 1 | High while the host interface is isolated |
| dbus_oe | output | 1 | Data bus drive enable; low means tri-state |
| core_sel | output | 1 | Gated select towards the register file |
| core_rd | output | 1 | Gated read towards the register file |
| core_wr | output | 1 | Gated write towards the register file |
| core_addr | output | ADDR_W | Gated address towards the register file |
| pf_status | output | 1 | Sticky power-fail status |

## Verification
Two situations can coincide and need directed tests. In the first, a deferred lockout is waiting for a read to end, and the read is released some ticks after the fixed delay has expired. In the second, a read is held from before power fail and runs into the stuck-access limit while the grace window is still open. The bench also holds an access while power is restored, so that the release tick and a live access meet. Each of these outcomes is judged at the lockout port on the tick boundary one step before and one step after the expected edge.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_LOCK = 2'd2
  } pfl_state_e;
endpackage

// File: rtl/pfl_sync.sv
module pfl_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= RST_VAL;
          else     chain_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= RST_VAL;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfl_tick_cnt.sv
module pfl_tick_cnt #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)                     cnt_o <= '0;
    else if (tick && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pfl_seq.sv
module pfl_seq
  import pfl_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int NORM_TICKS  = 32,
  parameter int GRACE_TICKS = 480
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pf_det,
  input  logic             grace_en,
  input  logic             access,
  input  logic             stuck,
  input  logic [CNT_W-1:0] wait_cnt,
  output pfl_state_e       state_o,
  output logic             lock_o
);
  localparam logic [CNT_W-1:0] NORM_LIM  = CNT_W'(NORM_TICKS);
  localparam logic [CNT_W-1:0] GRACE_LIM = CNT_W'(GRACE_TICKS);

  pfl_state_e state_q, state_d;
  logic       grace_q;
  logic       due;

  always_comb begin
    if (grace_q) due = (wait_cnt >= GRACE_LIM) || !grace_en;
    else         due = (wait_cnt >= NORM_LIM);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (pf_det) state_d = ST_WAIT;
      ST_WAIT: begin
        if (!pf_det)               state_d = ST_RUN;
        else if (stuck)            state_d = ST_LOCK;
        else if (due && !access)   state_d = ST_LOCK;
      end
      ST_LOCK: if (tick && !pf_det && !access) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      grace_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN && pf_det) grace_q <= grace_en;
    end
  end

  assign state_o = state_q;
  assign lock_o  = (state_q == ST_LOCK);
endmodule

// File: rtl/pfl_bus_guard.sv
module pfl_bus_guard
  import pfl_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int NORM_TICKS  = 32,
  parameter int GRACE_TICKS = 480,
  parameter int STUCK_TICKS = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_ms,
  input  logic              pwr_fail_n,
  input  logic              grace_en,
  input  logic              sts_clr,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              lockout,
  output logic              dbus_oe,
  output logic              core_sel,
  output logic              core_rd,
  output logic              core_wr,
  output logic [ADDR_W-1:0] core_addr,
  output logic              pf_status
);
  localparam int MAX_TICKS = (GRACE_TICKS > NORM_TICKS) ?
                             ((GRACE_TICKS > STUCK_TICKS) ? GRACE_TICKS : STUCK_TICKS) :
                             ((NORM_TICKS > STUCK_TICKS) ? NORM_TICKS : STUCK_TICKS);
  localparam int CNT_W = $clog2(MAX_TICKS + 2);
  localparam logic [CNT_W-1:0] STUCK_LIM = CNT_W'(STUCK_TICKS);

  logic             pf_ok;
  logic             pf_det;
  logic             access;
  logic             lock;
  logic             stuck;
  logic [CNT_W-1:0] wait_cnt;
  logic [CNT_W-1:0] stuck_cnt;
  pfl_state_e       state;

  pfl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .async_i(pwr_fail_n), .sync_o(pf_ok)
  );

  assign pf_det = !pf_ok;
  assign access = !host_cs_n && (!host_rd_n || !host_wr_n);

  pfl_tick_cnt #(.CNT_W(CNT_W)) u_wait_cnt (
    .clk(clk), .rst(rst), .clr(state != ST_WAIT), .tick(tick_ms), .cnt_o(wait_cnt)
  );

  pfl_tick_cnt #(.CNT_W(CNT_W)) u_stuck_cnt (
    .clk(clk), .rst(rst), .clr(!(pf_det && access)), .tick(tick_ms), .cnt_o(stuck_cnt)
  );

  assign stuck = (stuck_cnt > STUCK_LIM);

  pfl_seq #(
    .CNT_W(CNT_W), .NORM_TICKS(NORM_TICKS), .GRACE_TICKS(GRACE_TICKS)
  ) u_seq (
    .clk(clk), .rst(rst), .tick(tick_ms), .pf_det(pf_det), .grace_en(grace_en),
    .access(access), .stuck(stuck), .wait_cnt(wait_cnt), .state_o(state), .lock_o(lock)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lockout   <= 1'b0;
      dbus_oe   <= 1'b0;
      core_sel  <= 1'b0;
      core_rd   <= 1'b0;
      core_wr   <= 1'b0;
      core_addr <= '0;
      pf_status <= 1'b0;
    end else begin
      lockout   <= lock;
      dbus_oe   <= !lock && !host_cs_n && !host_rd_n;
      core_sel  <= !lock && !host_cs_n;
      core_rd   <= !lock && !host_cs_n && !host_rd_n;
      core_wr   <= !lock && !host_cs_n && !host_wr_n;
      core_addr <= lock ? '0 : host_addr;
      if (pf_det)       pf_status <= 1'b1;
      else if (sts_clr) pf_status <= 1'b0;
    end
  end
endmodule

// File: rtl/pfl_bus_guard_chk.sv
module pfl_bus_guard_chk (
  input logic clk,
  input logic rst,
  input logic tick_ms,
  input logic sts_clr,
  input logic pf_det,
  input logic lockout,
  input logic dbus_oe,
  input logic core_sel,
  input logic core_rd,
  input logic core_wr,
  input logic pf_status
);
  // R7: isolated interface drives nothing to the core or the bus
  a_r7_isolated: assert property (@(posedge clk) disable iff (rst)
    lockout |-> (!core_sel && !core_rd && !core_wr && !dbus_oe));

  // R2: lockout only ever follows a detected power fail
  a_r2_needs_pfail: assert property (@(posedge clk) disable iff (rst)
    $rose(lockout) |-> $past(pf_det, 2));

  // R8: held while power fail persists
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (pf_det && $past(pf_det) && lockout) |=> lockout);

  // R8: release follows a tick
  a_r8_release_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(lockout) |-> $past(tick_ms, 2));

  // R9: status clears only on a clear pulse with power restored
  a_r9_status_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(pf_status) |-> ($past(sts_clr) && !$past(pf_det)));
endmodule

bind pfl_bus_guard pfl_bus_guard_chk u_chk (
  .clk(clk), .rst(rst), .tick_ms(tick_ms), .sts_clr(sts_clr), .pf_det(pf_det),
  .lockout(lockout), .dbus_oe(dbus_oe), .core_sel(core_sel), .core_rd(core_rd),
  .core_wr(core_wr), .pf_status(pf_status)
);

// File: tb/test_pfl_bus_guard.sv
module test_pfl_bus_guard;
  localparam int AW = 5;
  localparam int TICK_DIV = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_ms = 1'b0;
  logic pwr_fail_n = 1'b1;
  logic grace_en = 1'b0;
  logic sts_clr = 1'b0;
  logic host_cs_n = 1'b1;
  logic host_rd_n = 1'b1;
  logic host_wr_n = 1'b1;
  logic [AW-1:0] host_addr = '0;
  logic lockout, dbus_oe, core_sel, core_rd, core_wr, pf_status;
  logic [AW-1:0] core_addr;

  int n_checks = 0;
  int n_fail = 0;
  int tick_no = 0;
  int div = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfl_bus_guard #(.ADDR_W(AW)) i_pfl_bus_guard (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .pwr_fail_n(pwr_fail_n),
    .grace_en(grace_en), .sts_clr(sts_clr), .host_cs_n(host_cs_n),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_addr(host_addr),
    .lockout(lockout), .dbus_oe(dbus_oe), .core_sel(core_sel), .core_rd(core_rd),
    .core_wr(core_wr), .core_addr(core_addr), .pf_status(pf_status)
  );

  always @(posedge clk) begin
    if (rst) begin
      div <= 0;
      tick_ms <= 1'b0;
    end else begin
      div <= (div == TICK_DIV - 1) ? 0 : div + 1;
      tick_ms <= (div == TICK_DIV - 1);
      if (tick_ms) tick_no <= tick_no + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_ticks(input int n);
    int start = tick_no;
    while (tick_no < start + n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic sync_to_tick();
    int s = tick_no;
    while (tick_no == s) @(negedge clk);
  endtask

  task automatic host_idle();
    host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1; host_addr = '0;
  endtask

  task automatic pulse_clr();
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic recover(input string tag);
    sync_to_tick();
    pwr_fail_n = 1'b1;
    wait_ticks(1);
    chk({tag, " R8 release on tick"}, lockout, 0);
    pulse_clr();
    chk({tag, " R9 status cleared"}, pf_status, 0);
  endtask

  task automatic t_reset();
    chk("R1 reset lockout", lockout, 0);
    chk("R1 reset dbus_oe", dbus_oe, 0);
    chk("R1 reset core_sel", core_sel, 0);
    chk("R9 reset status", pf_status, 0);
  endtask

  task automatic t_pass();
    host_cs_n = 1'b0; host_rd_n = 1'b0; host_addr = 5'h15;
    @(negedge clk);
    chk("R1 read sel", core_sel, 1);
    chk("R1 read rd", core_rd, 1);
    chk("R1 read oe", dbus_oe, 1);
    chk("R1 read addr", core_addr, 5'h15);
    host_rd_n = 1'b1; host_wr_n = 1'b0; host_addr = 5'h0a;
    @(negedge clk);
    chk("R1 write wr", core_wr, 1);
    chk("R1 write oe off", dbus_oe, 0);
    chk("R1 write addr", core_addr, 5'h0a);
    host_idle();
    @(negedge clk);
    chk("R1 idle sel", core_sel, 0);
  endtask

  task automatic t_normal();
    sync_to_tick();
    pwr_fail_n = 1'b0;
    wait_ticks(31);
    chk("R2 not yet locked at tick 31", lockout, 0);
    chk("R9 status set", pf_status, 1);
    wait_ticks(1);
    chk("R2 locked after tick 32", lockout, 1);
    host_cs_n = 1'b0; host_rd_n = 1'b0; host_wr_n = 1'b0; host_addr = 5'h1f;
    repeat (2) @(negedge clk);
    chk("R7 core_sel blocked", core_sel, 0);
    chk("R7 core_rd blocked", core_rd, 0);
    chk("R7 core_wr blocked", core_wr, 0);
    chk("R7 oe off", dbus_oe, 0);
    chk("R7 addr blocked", core_addr, 0);
    host_idle();
    pulse_clr();
    chk("R9 clear ignored while failing", pf_status, 1);
    sync_to_tick();
    pwr_fail_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 still locked before tick", lockout, 1);
    wait_ticks(1);
    chk("R8 released on tick", lockout, 0);
    chk("R9 status kept after recovery", pf_status, 1);
    pulse_clr();
    chk("R9 status cleared", pf_status, 0);
  endtask

  task automatic t_grace();
    grace_en = 1'b1;
    sync_to_tick();
    pwr_fail_n = 1'b0;
    wait_ticks(479);
    chk("R3 open at tick 479", lockout, 0);
    wait_ticks(1);
    chk("R3 locked after tick 480", lockout, 1);
    recover("grace");
    grace_en = 1'b0;
  endtask

  task automatic t_cut();
    grace_en = 1'b1;
    sync_to_tick();
    pwr_fail_n = 1'b0;
    wait_ticks(50);
    chk("R4 open inside grace", lockout, 0);
    grace_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 locked after cut", lockout, 1);
    recover("cut");
  endtask

  task automatic t_defer();
    sync_to_tick();
    pwr_fail_n = 1'b0;
    wait_ticks(28);
    host_cs_n = 1'b0; host_rd_n = 1'b0; host_addr = 5'h03;
    wait_ticks(6);
    chk("R5 deferred at tick 34", lockout, 0);
    chk("R5 access still served", core_rd, 1);
    wait_ticks(4);
    chk("R5 deferred at tick 38", lockout, 0);
    host_idle();
    repeat (3) @(negedge clk);
    chk("R5 locked after access ends", lockout, 1);
    recover("defer");
  endtask

  task automatic t_stuck();
    grace_en = 1'b1;
    host_cs_n = 1'b0; host_rd_n = 1'b0; host_addr = 5'h07;
    sync_to_tick();
    pwr_fail_n = 1'b0;
    wait_ticks(30);
    chk("R6 not forced at tick 30", lockout, 0);
    wait_ticks(1);
    chk("R6 forced after tick 31", lockout, 1);
    grace_en = 1'b0;
    sync_to_tick();
    pwr_fail_n = 1'b1;
    wait_ticks(1);
    chk("R8 held access blocks release", lockout, 1);
    host_idle();
    wait_ticks(1);
    chk("R8 release after access ends", lockout, 0);
    pulse_clr();
    chk("R9 status cleared after stuck", pf_status, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_pass();
    t_normal();
    t_grace();
    t_cut();
    t_defer();
    t_stuck();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule